// File: doc/BRIEF.md
# Edge-Window Bit Error Rate Alarm

This block estimates the error rate of a recovered serial stream from the timing of its transitions. Each clock cycle it may receive one transition pulse, together with a flag that tells whether that transition fell inside the expected timing window. A transition outside the window counts as one bit error. Errors are counted over a fixed measurement interval of 2^N transitions. At the end of each interval the count is compared with a limit taken from a threshold code.

The threshold code is logarithmic, in steps of 1/16 decade, and stands in for an analog level input. The alarm output is active low. It asserts when an interval exceeds the limit. It releases only when a later interval shows roughly half the limit or less, so a rate that hovers near the limit does not make it toggle. A threshold code of zero disables the alarm.

Top module: `ber_alarm_mon`

## Requirements
- R1: While rst_ni is low, alarm_no is high and both the transition counter and the error counter are cleared.
- R2: A cycle with edge_i high and in_win_i low adds one error. edge_i high with in_win_i high adds none. In a cycle with edge_i low, in_win_i has no effect.
- R3: An interval ends on the 2^N-th transition since reset or since the previous interval end. That transition's own error is included in the evaluation. Both counters then restart from zero, so no count carries into the next interval.
- R4: For threshold code k, values above 64 act as 64. The set limit is round(2^N * 10^(k/16 - LOG_BASE)), capped at 2^CNT_W - 2. With the defaults, codes 1 to 64 span 1e-10 to 1e-6 errors per transition.
- R5: If the alarm is off and the interval's error count is strictly greater than the set limit, alarm_no goes low in the cycle after the interval-ending transition.
- R6: If the alarm is on, it turns off after an interval whose error count is at most floor(set limit / 2). A count above that value keeps it on.
- R7: While level_i is 0, alarm_no is high from the next cycle onward. This takes priority over an interval end in the same cycle.
- R8: The error counter saturates at 2^CNT_W - 1 instead of wrapping.
- R9: alarm_no changes only in the cycle after an interval end, or after a cycle in which level_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| edge_i | input | 1 | One data transition observed this cycle |
| in_win_i | input | 1 | The transition fell inside the timing window |
| level_i | input | LVL_W | Threshold code, 1/16 decade per step; 0 disables |
| alarm_no | output | 1 | Error-rate alarm, active low |

## Verification
Two events can fall in the same cycle: the end of an interval and a zero threshold code. The bench provokes this by driving level_i to zero in the same cycle as the final transition of an interval whose error count would otherwise raise the alarm. It expects alarm_no to stay high. A second overlap occurs when the error counter is already saturated as the interval closes. An all-error interval at the top code is judged against the capped limit, so a counter that wraps is exposed.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int unsigned K_MAX = 64;

  // 10^(j/16) in Q12
  function automatic logic [63:0] mant_q12(input int j);
    case (j)
      0: return 64'd4096;   1: return 64'd4730;   2: return 64'd5462;   3: return 64'd6308;
      4: return 64'd7284;   5: return 64'd8411;   6: return 64'd9713;   7: return 64'd11217;
      8: return 64'd12953;  9: return 64'd14957;  10: return 64'd17273; 11: return 64'd19946;
      12: return 64'd23034; 13: return 64'd26599; 14: return 64'd30716; default: return 64'd35470;
    endcase
  endfunction

  function automatic logic [63:0] pow10(input int e);
    logic [63:0] r;
    r = 64'd1;
    for (int i = 0; i < e; i++) r = r * 64'd10;
    return r;
  endfunction

  // round(2^n * 10^(k/16 - log_base)), capped at 2^cnt_w - 2
  function automatic logic [63:0] thr_calc(input int k, input int n, input int log_base,
                                           input int cnt_w);
    logic [63:0] num, den, t, cap;
    num = (64'd1 << n) * mant_q12(k % 16) * pow10(k / 16);
    den = 64'd4096 * pow10(log_base);
    t   = (num + (den >> 1)) / den;
    cap = (64'd1 << cnt_w) - 64'd2;
    return (t > cap) ? cap : t;
  endfunction
endpackage

// File: rtl/ber_thr_lut.sv
module ber_thr_lut #(
  parameter int N        = 34,
  parameter int LOG_BASE = 10,
  parameter int CNT_W    = 16,
  parameter int LVL_W    = 7
) (
  input  logic [LVL_W-1:0] code_i,
  output logic [CNT_W-1:0] set_o,
  output logic [CNT_W-1:0] clr_o
);
  localparam int TAB_N = ber_pkg::K_MAX + 1;

  logic [CNT_W-1:0] tab [TAB_N];
  logic [LVL_W-1:0] idx;

  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam logic [63:0] T64 = ber_pkg::thr_calc(k, N, LOG_BASE, CNT_W);
    assign tab[k] = T64[CNT_W-1:0];
  end

  always_comb begin
    idx   = (code_i > LVL_W'(ber_pkg::K_MAX)) ? LVL_W'(ber_pkg::K_MAX) : code_i;
    set_o = tab[idx];
    clr_o = set_o >> 1;
  end
endmodule

// File: rtl/ber_win_cnt.sv
module ber_win_cnt #(
  parameter int N     = 34,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             in_win_i,
  output logic             done_o,
  output logic [CNT_W-1:0] err_total_o,
  output logic [CNT_W-1:0] err_q_o
);
  logic [N-1:0]     trans_q;
  logic [CNT_W-1:0] err_q;
  logic             miss;

  always_comb begin
    miss        = edge_i & ~in_win_i;
    err_total_o = (miss && (err_q != '1)) ? err_q + 1'b1 : err_q;
    done_o      = edge_i && (trans_q == '1);
    err_q_o     = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trans_q <= '0;
      err_q   <= '0;
    end else if (edge_i) begin
      if (done_o) begin
        trans_q <= '0;
        err_q   <= '0;
      end else begin
        trans_q <= trans_q + 1'b1;
        err_q   <= err_total_o;
      end
    end
  end
endmodule

// File: rtl/ber_alarm_fsm.sv
module ber_alarm_fsm #(
  parameter int CNT_W = 16,
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic [CNT_W-1:0] set_i,
  input  logic [CNT_W-1:0] clr_i,
  output logic             alarm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_o <= 1'b0;
    end else if (level_i == '0) begin
      alarm_o <= 1'b0;
    end else if (done_i) begin
      if (!alarm_o && (err_i > set_i)) alarm_o <= 1'b1;
      else if (alarm_o && (err_i <= clr_i)) alarm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ber_alarm_mon.sv
module ber_alarm_mon #(
  parameter int N        = 34,
  parameter int LOG_BASE = 10,
  parameter int CNT_W    = 16,
  parameter int LVL_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             in_win_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             alarm_no
);
  logic             done;
  logic [CNT_W-1:0] err_final;
  logic [CNT_W-1:0] err_cnt;
  logic [CNT_W-1:0] thr_set;
  logic [CNT_W-1:0] thr_clr;
  logic             alarm;

  ber_win_cnt #(.N(N), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .edge_i, .in_win_i,
    .done_o(done), .err_total_o(err_final), .err_q_o(err_cnt)
  );

  ber_thr_lut #(.N(N), .LOG_BASE(LOG_BASE), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_lut (
    .code_i(level_i), .set_o(thr_set), .clr_o(thr_clr)
  );

  ber_alarm_fsm #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_fsm (
    .clk_i, .rst_ni, .level_i, .done_i(done), .err_i(err_final),
    .set_i(thr_set), .clr_i(thr_clr), .alarm_o(alarm)
  );

  assign alarm_no = ~alarm;
endmodule

// File: rtl/ber_alarm_chk.sv
module ber_alarm_chk #(
  parameter int CNT_W = 16,
  parameter int LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             edge_i,
  input logic             in_win_i,
  input logic [LVL_W-1:0] level_i,
  input logic             alarm_no,
  input logic             done,
  input logic [CNT_W-1:0] err_final,
  input logic [CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0] thr_set,
  input logic [CNT_W-1:0] thr_clr
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r1: assert (alarm_no && err_cnt == '0);
    end
  end

  p_no_edge_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(err_cnt));

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (err_cnt == '0));

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && alarm_no && level_i != '0 && err_final > thr_set) |=> !alarm_no);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !alarm_no && level_i != '0 && err_final <= thr_clr) |=> alarm_no);

  p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> alarm_no);

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !done) |=> (err_cnt >= $past(err_cnt)));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && level_i != '0) |=> $stable(alarm_no));
endmodule

bind ber_alarm_mon ber_alarm_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_i), .in_win_i(in_win_i),
  .level_i(level_i), .alarm_no(alarm_no), .done(done), .err_final(err_final),
  .err_cnt(err_cnt), .thr_set(thr_set), .thr_clr(thr_clr)
);

// File: tb/tb_ber_alarm_mon.sv
`timescale 1ns/1ps
module tb_ber_alarm_mon;
  localparam int N        = 12;
  localparam int LOG_BASE = 4;
  localparam int CNT_W    = 10;
  localparam int LVL_W    = 7;
  localparam int TRANS    = 1 << N;
  localparam int SAT      = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             edge_i = 1'b0;
  logic             in_win_i = 1'b1;
  logic [LVL_W-1:0] level_i = '0;
  logic             alarm_no;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_alarm = 1'b0;
  bit done_flag = 1'b0;

  ber_alarm_mon #(.N(N), .LOG_BASE(LOG_BASE), .CNT_W(CNT_W), .LVL_W(LVL_W)) dut (
    .clk_i, .rst_ni, .edge_i, .in_win_i, .level_i, .alarm_no
  );

  always #10 clk_i = ~clk_i;

  function automatic int set_lim(input int code);
    int k;
    real r;
    int t;
    k = (code > 64) ? 64 : code;
    r = real'(TRANS) * (10.0 ** (real'(k) / 16.0 - real'(LOG_BASE)));
    t = $rtoi(r + 0.5);
    return (t > SAT - 1) ? SAT - 1 : t;
  endfunction

  function automatic bit next_alarm(input bit cur, input int code, input int nerr);
    int e;
    e = (nerr > SAT) ? SAT : nerr;
    if (code == 0) return 1'b0;
    if (!cur && e > set_lim(code)) return 1'b1;
    if (cur && e <= set_lim(code) / 2) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: alarm_no=%b expected %b", req, act, expv);
    end
  endtask

  // dis_mode: 0 none, 1 zero code mid-interval, 2 zero code on the last transition
  task automatic run_interval(input int code, input int nerr, input int dis_mode, input string req);
    int left_e;
    left_e = nerr;
    level_i = LVL_W'(code);
    for (int i = 0; i < TRANS; i++) begin
      while (($urandom % 8) == 0) begin
        edge_i = 1'b0;
        in_win_i = $urandom % 2;
        @(posedge clk_i); @(negedge clk_i);
      end
      if (dis_mode == 1 && i == TRANS / 2) begin
        edge_i = 1'b0;
        level_i = '0;
        @(posedge clk_i); @(negedge clk_i);
        exp_alarm = 1'b0;
        check("R7 zero code mid-interval", alarm_no, 1'b1);
        level_i = LVL_W'(code);
      end
      if (i == TRANS / 2 + 8) check("R9 stable mid-interval", alarm_no, ~exp_alarm);
      edge_i = 1'b1;
      in_win_i = !((($urandom % (TRANS - i)) < left_e) || (left_e >= TRANS - i));
      if (!in_win_i) left_e--;
      if (dis_mode == 2 && i == TRANS - 1) level_i = '0;
      @(posedge clk_i); @(negedge clk_i);
    end
    edge_i = 1'b0;
    in_win_i = 1'b1;
    exp_alarm = next_alarm(exp_alarm, (dis_mode == 2) ? 0 : code, nerr);
    check(req, alarm_no, ~exp_alarm);
    level_i = LVL_W'(code);
  endtask

  initial begin
    #(20.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: alarm_no=%b expected end of run", alarm_no);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    level_i = 7'd32;
    repeat (3) @(negedge clk_i);
    check("R1 reset state", alarm_no, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // code 32 -> set limit 41, clear limit 20
    run_interval(32, 41, 0, "R4 at set limit");
    run_interval(32, 40, 0, "R3 no carry between intervals");
    run_interval(32, 42, 0, "R5 above set limit");
    run_interval(32, 21, 0, "R6 hold above clear limit");
    run_interval(32, 20, 0, "R6 clear at half limit");
    run_interval(32, 0, 0, "R2 idle window flags ignored");
    run_interval(32, 60, 0, "R5 set again");
    run_interval(100, 500, 0, "R4 code above 64 clamps");
    run_interval(64, TRANS, 0, "R8 saturated count beats cap");
    run_interval(64, 0, 0, "R6 clear after saturation");
    run_interval(32, 50, 0, "R5 set before disable");
    run_interval(32, 50, 1, "R7 rearm after mid disable");
    run_interval(32, 50, 2, "R7 disable wins at interval end");
    run_interval(32, 10, 0, "R6 quiet after disable");

    for (int r = 0; r < 14; r++) begin
      int code, lim, n, hi;
      code = 20 + ($urandom % 41);
      lim = set_lim(code);
      hi = 2 * lim + 10;
      if (hi > TRANS) hi = TRANS;
      n = $urandom % (hi + 1);
      for (int t = 0; t < 50; t++) begin
        if ((n - lim <= 2 && lim - n <= 2) || (n - lim / 2 <= 2 && lim / 2 - n <= 2))
          n = $urandom % (hi + 1);
      end
      if ((n - lim <= 2 && lim - n <= 2) || (n - lim / 2 <= 2 && lim / 2 - n <= 2)) n = hi;
      run_interval(code, n, 0, "R5/R6 random density");
    end

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end
endmodule